// File: doc/BRIEF.md
# Horizontal Drive Start-Up Controller

This block keeps the horizontal deflection drive safe around power-up, standby and loss of line lock. After reset the drive stays off. The controller waits for a single-cycle pulse that reports that every control register has been written. It then asks a line-oscillator trimmer to calibrate and brings the drive pulse up with a soft start. During the soft start the duty cycle rises step by step, counted in lines, from 0% to 50%.

A start-mode input chooses the start-up order. With the input at 1, the drive waits for calibration to finish. With the input at 0, the drive and its ramp start at once while calibration runs alongside. If the lock detector reports loss of lock while the drive runs, calibration is requested again and the drive is not interrupted. Standby or a reset at any moment forces the drive off and the duty to zero. A new configuration pulse is then needed to start again.

A built-in per-line pulse generator turns the 7-bit duty value into the drive waveform. It counts a line period given in clocks. Its output is high while the count is below duty × period / 128.

Top module: `hdrv_startup_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, cal_req_o, drive_en_o and hpulse_o are 0 and duty_o is 0.
- R2: Without a cfg_loaded_i pulse taken while stby_n_i is 1, no calibration is requested and the drive stays off. Line ticks have no effect. A cfg_loaded_i pulse given while stby_n_i is 0 is ignored.
- R3: With start_mode_i = 1 at the configuration pulse, cal_req_o is 1 from the cycle after the pulse. drive_en_o stays 0 and duty_o stays 0 until calibration completes, whatever line ticks arrive.
- R4: cal_done_i while cal_req_o is 1 clears cal_req_o on the next cycle. If the drive was off, drive_en_o rises on that same cycle with duty_o at 0.
- R5: While ramping, duty_o increases by exactly 1 every RAMP_DIV line ticks. It stops at 64 (50%), and further ticks leave it at 64.
- R6: In every window of LINE_CLKS consecutive clocks with a constant duty, hpulse_o is high for floor(duty_o × LINE_CLKS / 128) clocks. hpulse_o is never high when the previous duty was 0.
- R7: With start_mode_i = 0 at the configuration pulse, cal_req_o and drive_en_o both rise on the cycle after the pulse. The duty ramps while calibration is still pending.
- R8: in_lock_i = 0 while the drive is on and no calibration is pending sets cal_req_o on the next cycle. drive_en_o and duty_o are unchanged.
- R9: stby_n_i = 0 makes cal_req_o, drive_en_o and duty_o all 0 on the next cycle. After standby is left, nothing restarts without a new configuration pulse.
- R10: Asserting reset during operation immediately forces all outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_loaded_i | input | 1 | Single-cycle pulse: all control registers written |
| stby_n_i | input | 1 | 0 = standby (drive off), 1 = normal |
| start_mode_i | input | 1 | 1 = wait for calibration, 0 = drive before calibration |
| cal_done_i | input | 1 | Trimmer reports the oscillator frequency is correct |
| in_lock_i | input | 1 | Line lock detector, 1 = locked |
| line_tick_i | input | 1 | Single-cycle pulse per line |
| cal_req_o | output | 1 | Calibration request to the trimmer |
| drive_en_o | output | 1 | Horizontal drive enabled |
| duty_o | output | 7 | Drive duty, 0..64 = 0%..50% |
| hpulse_o | output | 1 | Per-line horizontal drive pulse |

## Verification
The bench builds the block with LINE_CLKS = 16 and RAMP_DIV = 2. With these values a full ramp takes 128 line ticks. A single 16-clock window then shows a whole PWM period, and the high time at duty 32 and duty 64 is 4 and 8 clocks. A RAMP_DIV above 1 also selects the prescaler branch, so the bench can show that duty_o moves on every second tick only.

// File: rtl/hdrv_pkg.sv
package hdrv_pkg;
  localparam int DUTY_W    = 7;
  localparam int DUTY_HALF = 1 << (DUTY_W - 1);

  typedef enum logic [1:0] {
    DRV_OFF  = 2'd0,
    DRV_RAMP = 2'd1,
    DRV_ON   = 2'd2
  } drv_e;
endpackage

// File: rtl/hdrv_seq.sv
module hdrv_seq
  import hdrv_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic stby_n,
  input  logic cfg_done,
  input  logic start_mode,
  input  logic cal_done,
  input  logic in_lock,
  input  logic ramp_full,
  output logic cal_req,
  output drv_e drv_st
);
  logic busy_q, busy_d;
  logic cal_q, cal_d;
  drv_e drv_q, drv_d;

  always_comb begin
    busy_d = busy_q;
    cal_d  = cal_q;
    drv_d  = drv_q;
    if (!stby_n) begin
      busy_d = 1'b0;
      cal_d  = 1'b0;
      drv_d  = DRV_OFF;
    end else if (!busy_q) begin
      if (cfg_done) begin
        busy_d = 1'b1;
        cal_d  = 1'b1;
        if (!start_mode) drv_d = DRV_RAMP;
      end
    end else begin
      if (cal_q) begin
        if (cal_done) begin
          cal_d = 1'b0;
          if (drv_q == DRV_OFF) drv_d = DRV_RAMP;
        end
      end else if (drv_q != DRV_OFF && !in_lock) begin
        cal_d = 1'b1;
      end
      if (drv_q == DRV_RAMP && ramp_full) drv_d = DRV_ON;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cal_q  <= 1'b0;
      drv_q  <= DRV_OFF;
    end else begin
      busy_q <= busy_d;
      cal_q  <= cal_d;
      drv_q  <= drv_d;
    end
  end

  assign cal_req = cal_q;
  assign drv_st  = drv_q;
endmodule

// File: rtl/hdrv_ramp.sv
module hdrv_ramp
  import hdrv_pkg::*;
#(
  parameter int RAMP_DIV = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              run,
  input  logic              line_tick,
  output logic [DUTY_W-1:0] duty,
  output logic              full
);
  logic              step;
  logic [DUTY_W-1:0] duty_q, duty_d;
  logic              duty_en;

  generate
    if (RAMP_DIV > 1) begin : g_pre
      localparam int PRE_W = $clog2(RAMP_DIV);
      localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(RAMP_DIV - 1);
      logic [PRE_W-1:0] pre_q, pre_d;
      logic             pre_en;

      always_comb begin
        pre_en = 1'b0;
        pre_d  = pre_q;
        if (!run) begin
          pre_en = (pre_q != '0);
          pre_d  = '0;
        end else if (line_tick) begin
          pre_en = 1'b1;
          pre_d  = (pre_q == PRE_LAST) ? '0 : pre_q + 1'b1;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      pre_q <= '0;
        else if (pre_en) pre_q <= pre_d;
      end

      assign step = run && line_tick && (pre_q == PRE_LAST);
    end else begin : g_nopre
      assign step = run && line_tick;
    end
  endgenerate

  assign full = (duty_q == DUTY_W'(DUTY_HALF));

  always_comb begin
    duty_en = 1'b0;
    duty_d  = duty_q;
    if (clr) begin
      duty_en = (duty_q != '0);
      duty_d  = '0;
    end else if (step && !full) begin
      duty_en = 1'b1;
      duty_d  = duty_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       duty_q <= '0;
    else if (duty_en) duty_q <= duty_d;
  end

  assign duty = duty_q;
endmodule

// File: rtl/hdrv_pwm.sv
module hdrv_pwm
  import hdrv_pkg::*;
#(
  parameter int LINE_CLKS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [DUTY_W-1:0] duty,
  output logic              pulse
);
  localparam int LC_W   = (LINE_CLKS > 1) ? $clog2(LINE_CLKS) : 1;
  localparam int PROD_W = LC_W + DUTY_W + 1;
  localparam logic [LC_W-1:0] CNT_LAST = LC_W'(LINE_CLKS - 1);

  logic [LC_W-1:0]   cnt_q, cnt_d;
  logic [PROD_W-1:0] prod;
  logic [LC_W:0]     thr;
  logic              pulse_q, pulse_d;

  always_comb begin
    cnt_d   = (cnt_q == CNT_LAST) ? '0 : cnt_q + 1'b1;
    prod    = PROD_W'(duty) * PROD_W'(LINE_CLKS);
    thr     = prod[PROD_W-1:DUTY_W];
    pulse_d = enable && ({1'b0, cnt_q} < thr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      pulse_q <= pulse_d;
    end
  end

  assign pulse = pulse_q;
endmodule

// File: rtl/hdrv_startup_ctrl.sv
module hdrv_startup_ctrl
  import hdrv_pkg::*;
#(
  parameter int LINE_CLKS = 16,
  parameter int RAMP_DIV  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_loaded_i,
  input  logic              stby_n_i,
  input  logic              start_mode_i,
  input  logic              cal_done_i,
  input  logic              in_lock_i,
  input  logic              line_tick_i,
  output logic              cal_req_o,
  output logic              drive_en_o,
  output logic [DUTY_W-1:0] duty_o,
  output logic              hpulse_o
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  drv_e       drv_st;
  logic       ramp_full;
  logic       ramp_clr;
  logic       ramp_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  hdrv_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .stby_n     (stby_n_i),
    .cfg_done   (cfg_loaded_i),
    .start_mode (start_mode_i),
    .cal_done   (cal_done_i),
    .in_lock    (in_lock_i),
    .ramp_full  (ramp_full),
    .cal_req    (cal_req_o),
    .drv_st     (drv_st)
  );

  assign ramp_clr   = !stby_n_i || (drv_st == DRV_OFF);
  assign ramp_run   = (drv_st == DRV_RAMP);
  assign drive_en_o = (drv_st != DRV_OFF);

  hdrv_ramp #(.RAMP_DIV(RAMP_DIV)) u_ramp (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .clr       (ramp_clr),
    .run       (ramp_run),
    .line_tick (line_tick_i),
    .duty      (duty_o),
    .full      (ramp_full)
  );

  hdrv_pwm #(.LINE_CLKS(LINE_CLKS)) u_pwm (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .enable (drive_en_o),
    .duty   (duty_o),
    .pulse  (hpulse_o)
  );
endmodule

// File: rtl/hdrv_chk.sv
module hdrv_chk
  import hdrv_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              stby_n_i,
  input logic              cal_done_i,
  input logic              in_lock_i,
  input logic              cal_req_o,
  input logic              drive_en_o,
  input logic [DUTY_W-1:0] duty_o,
  input logic              hpulse_o
);
  AST_STBY_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !stby_n_i |=> (!cal_req_o && !drive_en_o && duty_o == '0)); // R9

  AST_DUTY_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    duty_o <= DUTY_W'(DUTY_HALF)); // R5

  AST_DUTY_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (stby_n_i && drive_en_o) |=>
      (duty_o == $past(duty_o) || duty_o == $past(duty_o) + 1'b1)); // R5

  AST_ZERO_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (duty_o == '0) |=> !hpulse_o); // R6

  AST_CAL_END: assert property (@(posedge clk) disable iff (!rst_n)
    (stby_n_i && cal_req_o && cal_done_i) |=> !cal_req_o); // R4

  AST_LOCK_RECAL: assert property (@(posedge clk) disable iff (!rst_n)
    (stby_n_i && drive_en_o && !cal_req_o && !in_lock_i) |=> cal_req_o); // R8
endmodule

bind hdrv_startup_ctrl hdrv_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .stby_n_i   (stby_n_i),
  .cal_done_i (cal_done_i),
  .in_lock_i  (in_lock_i),
  .cal_req_o  (cal_req_o),
  .drive_en_o (drive_en_o),
  .duty_o     (duty_o),
  .hpulse_o   (hpulse_o)
);

// File: tb/hdrv_startup_ctrl_bench.sv
`timescale 1ns/1ps
module hdrv_startup_ctrl_bench;
  localparam int LC = 16;
  localparam int RD = 2;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_loaded, stby_n, start_mode, cal_done, in_lock, line_tick;
  logic       cal_req, drive_en, hpulse;
  logic [6:0] duty;
  int         total = 0;
  int         bad = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  hdrv_startup_ctrl #(.LINE_CLKS(LC), .RAMP_DIV(RD)) u_hdrv_startup_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_loaded_i(cfg_loaded), .stby_n_i(stby_n),
    .start_mode_i(start_mode), .cal_done_i(cal_done), .in_lock_i(in_lock),
    .line_tick_i(line_tick), .cal_req_o(cal_req), .drive_en_o(drive_en),
    .duty_o(duty), .hpulse_o(hpulse)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_outs(input string req, input int c, input int d, input int u);
    chk({req, " cal_req"}, int'(cal_req), c);
    chk({req, " drive_en"}, int'(drive_en), d);
    chk({req, " duty"}, int'(duty), u);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_cfg();
    @(negedge clk) cfg_loaded = 1'b1;
    @(negedge clk) cfg_loaded = 1'b0;
  endtask

  task automatic pulse_cal();
    @(negedge clk) cal_done = 1'b1;
    @(negedge clk) cal_done = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) line_tick = 1'b1;
      @(negedge clk) line_tick = 1'b0;
    end
  endtask

  task automatic count_high(input string req, input int exp);
    int hi = 0;
    for (int i = 0; i < LC; i++) begin
      @(negedge clk);
      if (hpulse) hi++;
    end
    chk(req, hi, exp);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; cfg_loaded = 0; stby_n = 0; start_mode = 1;
    cal_done = 0; in_lock = 1; line_tick = 0;
    idle(3);
    chk_outs("R1 in reset", 0, 0, 0);
    chk("R1 hpulse", int'(hpulse), 0);
    @(negedge clk) rst_n = 1'b1;
    idle(4);
    chk_outs("R1 after release", 0, 0, 0);
  endtask

  task automatic t_no_cfg();
    pulse_cfg();
    idle(2);
    chk_outs("R2 cfg in standby", 0, 0, 0);
    @(negedge clk) stby_n = 1'b1;
    ticks(6);
    idle(4);
    chk_outs("R2 no cfg pulse", 0, 0, 0);
  endtask

  task automatic t_wait_cal();
    start_mode = 1'b1;
    pulse_cfg();
    chk_outs("R3 cal requested", 1, 0, 0);
    ticks(8);
    chk_outs("R3 held during cal", 1, 0, 0);
    count_high("R3 no pulse", 0);
    pulse_cal();
    chk_outs("R4 cal done", 0, 1, 0);
  endtask

  task automatic t_ramp();
    ticks(1);
    chk("R5 one tick no step", int'(duty), 0);
    ticks(1);
    chk("R5 two ticks step", int'(duty), 1);
    ticks(62);
    chk("R5 mid ramp", int'(duty), 32);
    count_high("R6 duty 32", 4);
    ticks(64);
    chk("R5 ramp end", int'(duty), 64);
    ticks(6);
    chk("R5 saturates", int'(duty), 64);
    count_high("R6 duty 64", 8);
  endtask

  task automatic t_lock();
    @(negedge clk) in_lock = 1'b0;
    @(negedge clk);
    chk_outs("R8 recal on unlock", 1, 1, 64);
    in_lock = 1'b1;
    pulse_cal();
    chk_outs("R8 recal finished", 0, 1, 64);
  endtask

  task automatic t_standby();
    @(negedge clk) stby_n = 1'b0;
    @(negedge clk);
    chk_outs("R9 standby", 0, 0, 0);
    pulse_cal();
    stby_n = 1'b1;
    ticks(4);
    idle(3);
    chk_outs("R9 no restart", 0, 0, 0);
  endtask

  task automatic t_early_drive();
    start_mode = 1'b0;
    pulse_cfg();
    chk_outs("R7 drive with cal", 1, 1, 0);
    ticks(4);
    chk_outs("R7 ramp during cal", 1, 1, 2);
    pulse_cal();
    chk_outs("R4 cal done, drive on", 0, 1, 2);
  endtask

  task automatic t_mid_reset();
    ticks(6);
    @(negedge clk) rst_n = 1'b0;
    #1;
    chk_outs("R10 async reset", 0, 0, 0);
    chk("R10 hpulse", int'(hpulse), 0);
    @(negedge clk) rst_n = 1'b1;
    idle(3);
  endtask

  initial begin
    t_reset();
    t_no_cfg();
    t_wait_cal();
    t_ramp();
    t_lock();
    t_standby();
    t_early_drive();
    t_mid_reset();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(5 * 50000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule